// File: doc/BRIEF.md
# Carrier Tracking Loop Filter

This block performs one update of a second-order carrier tracking loop in signed fixed point. Each word has 14 fraction bits, so 0x4000 stands for 1.0. On a start request it takes four correlator outputs and adds prompt to early in each arm. It forms a phase error from the quadrature sum, divides it by the root-sum-square of both sums, and flips its sign when the in-phase sum is negative. The result is scaled by a programmable gain and passed through a proportional-plus-derivative stage that uses the increment kept from the previous update. The output of that stage, shifted right by 14, is added into a saturating carrier frequency word.

A shift-and-subtract square root unit and a restoring divider do the arithmetic. Each runs one step per clock, so an update takes several dozen cycles. The caller pulses `start`, waits for the one-cycle `done` pulse, and then reads the new frequency word and the increment. The gain `k` and the derivative weight `d` sit in registers that can be written at any time. An update uses the values held on the cycle its start was accepted.

Top module: `carrier_loop_filter`

## Requirements
- R1: After reset, `freq_word` and `incr_word` read zero, `busy` and `done` are low, and the gain registers hold k = -9 and d = 21.
- R2: The in-phase sum is `i_prompt + i_early` and the quadrature sum is `q_prompt + q_early`, each formed without overflow from signed inputs.
- R3: The new increment is -k × (Qs × 2^14) × s / floor(sqrt(Is² + Qs²)), with the division truncated toward zero. Here s = -1 when Is < 0 and s = +1 when Is ≥ 0. The increment is clipped to the signed range of `incr_word`.
- R4: When both sums are zero, the increment is zero and no division is performed.
- R5: The frequency word gains (step >>> 14), where step = (d+1) × increment − d × previous increment, and the shift is arithmetic (rounding toward minus infinity). `freq_word` changes only on the cycle `done` is high.
- R6: At the end of each update the new increment becomes the previous increment and appears on `incr_word`. Reset clears it to zero. `incr_word` changes only on the cycle `done` is high.
- R7: The frequency word saturates at 0x7FFFFFFF and 0x80000000 instead of wrapping.
- R8: A cycle with `cfg_we` high loads `cfg_k` and `cfg_d` into the gain registers. The next accepted update uses them.
- R9: `start` is accepted only while `busy` is low. `busy` rises on the next cycle and stays high until the update ends. `done` is a single-cycle pulse with `busy` low. A `start` raised while `busy` is high is ignored and produces no second result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one loop update |
| i_prompt | input | CORR_W | In-phase prompt correlation, signed |
| i_early | input | CORR_W | In-phase early correlation, signed |
| q_prompt | input | CORR_W | Quadrature prompt correlation, signed |
| q_early | input | CORR_W | Quadrature early correlation, signed |
| cfg_we | input | 1 | Gain register write strobe |
| cfg_k | input | 16 | Loop gain k, signed |
| cfg_d | input | 16 | Derivative weight d, signed |
| busy | output | 1 | Update in progress |
| done | output | 1 | One-cycle end-of-update pulse |
| freq_word | output | FREQ_W | Carrier frequency word, signed, saturating |
| incr_word | output | FREQ_W | Most recent increment, signed |

## Verification
The assertions assume the caller treats `done` as the only point where results move. They also assume `start` is meaningful only while `busy` is low. The bench holds the correlator inputs and gains steady from the accepted start until `done`, except in one scenario that deliberately re-raises `start` with different data during a run to show that it is ignored. Gain writes are issued only between updates, and the values cover negative, zero-sum and full-scale gain cases, so the saturation corners are reached without relying on untested input timing.

// File: rtl/cplf_pkg.sv
package cplf_pkg;

    localparam int GAIN_W    = 16;
    localparam int FRAC_BITS = 14;
    localparam int K_DEFAULT = -9;
    localparam int D_DEFAULT = 21;

    typedef logic signed [GAIN_W-1:0] gain_t;

    typedef struct packed {
        gain_t k;
        gain_t d;
    } gains_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SQ_GO,
        S_SQ_WAIT,
        S_DV_GO,
        S_DV_WAIT,
        S_UPD
    } cplf_state_e;

    function automatic gains_t reset_gains();
        gains_t g;
        g.k = gain_t'(K_DEFAULT);
        g.d = gain_t'(D_DEFAULT);
        return g;
    endfunction

endpackage

// File: rtl/cplf_isqrt.sv
module cplf_isqrt #(
    parameter int ROOT_W = 17
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  go,
    input  logic [2*ROOT_W-1:0]   rad,
    output logic                  done,
    output logic [ROOT_W-1:0]     root
);
    localparam int RAD_W = 2 * ROOT_W;
    localparam int REM_W = ROOT_W + 2;
    localparam int CNT_W = $clog2(ROOT_W + 1);

    logic [RAD_W-1:0]  rad_q;
    logic [REM_W-1:0]  rem_q;
    logic [ROOT_W-1:0] root_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              run_q;

    logic [REM_W-1:0]  rem_sh;
    logic [REM_W-1:0]  trial;
    logic              fits;

    always_comb begin
        rem_sh = {rem_q[ROOT_W-1:0], rad_q[RAD_W-1 -: 2]};
        trial  = {root_q, 2'b01};
        fits   = (rem_sh >= trial);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rad_q  <= '0;
            rem_q  <= '0;
            root_q <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                rad_q  <= rad;
                rem_q  <= '0;
                root_q <= '0;
                cnt_q  <= CNT_W'(ROOT_W);
                run_q  <= 1'b1;
            end else if (run_q) begin
                rad_q  <= rad_q << 2;
                rem_q  <= fits ? (rem_sh - trial) : rem_sh;
                root_q <= {root_q[ROOT_W-2:0], fits};
                cnt_q  <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    run_q <= 1'b0;
                    done  <= 1'b1;
                end
            end
        end
    end

    assign root = root_q;

endmodule

// File: rtl/cplf_divu.sv
module cplf_divu #(
    parameter int N_W = 48,
    parameter int D_W = 17
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            go,
    input  logic [N_W-1:0]  num,
    input  logic [D_W-1:0]  den,
    output logic            done,
    output logic [N_W-1:0]  quo
);
    localparam int CNT_W = $clog2(N_W + 1);

    logic [D_W:0]   rem_q;
    logic [N_W-1:0] quo_q;
    logic [D_W-1:0] den_q;
    logic [CNT_W-1:0] cnt_q;
    logic           run_q;

    logic [D_W:0]   rem_sh;
    logic           fits;

    always_comb begin
        rem_sh = {rem_q[D_W-1:0], quo_q[N_W-1]};
        fits   = (rem_sh >= {1'b0, den_q});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            quo_q <= '0;
            den_q <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                rem_q <= '0;
                quo_q <= num;
                den_q <= den;
                cnt_q <= CNT_W'(N_W);
                run_q <= 1'b1;
            end else if (run_q) begin
                rem_q <= fits ? (rem_sh - {1'b0, den_q}) : rem_sh;
                quo_q <= {quo_q[N_W-2:0], fits};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    run_q <= 1'b0;
                    done  <= 1'b1;
                end
            end
        end
    end

    assign quo = quo_q;

endmodule

// File: rtl/carrier_loop_filter.sv
module carrier_loop_filter
    import cplf_pkg::*;
#(
    parameter int CORR_W = 16,
    parameter int FREQ_W = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic signed [CORR_W-1:0] i_prompt,
    input  logic signed [CORR_W-1:0] i_early,
    input  logic signed [CORR_W-1:0] q_prompt,
    input  logic signed [CORR_W-1:0] q_early,
    input  logic                     cfg_we,
    input  logic signed [GAIN_W-1:0] cfg_k,
    input  logic signed [GAIN_W-1:0] cfg_d,
    output logic                     busy,
    output logic                     done,
    output logic signed [FREQ_W-1:0] freq_word,
    output logic signed [FREQ_W-1:0] incr_word
);
    localparam int SUM_W  = CORR_W + 1;
    localparam int ROOT_W = SUM_W;
    localparam int RAD_W  = 2 * ROOT_W;
    localparam int PROD_W = GAIN_W + 1 + SUM_W;
    localparam int NUM_W  = PROD_W + FRAC_BITS;
    localparam int QS_W   = NUM_W + 1;
    localparam int STEP_W = GAIN_W + FREQ_W + 3;
    localparam int FSUM_W = STEP_W + 1;

    localparam logic signed [QS_W-1:0] INC_MAX =
        {{(QS_W-FREQ_W+1){1'b0}}, {(FREQ_W-1){1'b1}}};
    localparam logic signed [QS_W-1:0] INC_MIN =
        {{(QS_W-FREQ_W+1){1'b1}}, {(FREQ_W-1){1'b0}}};
    localparam logic signed [FSUM_W-1:0] F_MAX =
        {{(FSUM_W-FREQ_W+1){1'b0}}, {(FREQ_W-1){1'b1}}};
    localparam logic signed [FSUM_W-1:0] F_MIN =
        {{(FSUM_W-FREQ_W+1){1'b1}}, {(FREQ_W-1){1'b0}}};

    cplf_state_e state_q;
    gains_t      gains_q;
    gains_t      op_q;
    logic signed [SUM_W-1:0]  isum_q, qsum_q;
    logic signed [FREQ_W-1:0] incr_q, prev_q, freq_q;
    logic                     done_q;

    // operand preparation
    logic signed [RAD_W-1:0]  isq, qsq;
    logic [RAD_W-1:0]         rad;
    logic signed [GAIN_W:0]   negk;
    logic signed [PROD_W-1:0] prod;
    logic signed [NUM_W-1:0]  num_s;
    logic [NUM_W-1:0]         num_mag;
    logic                     num_neg;

    always_comb begin
        isq     = RAD_W'(isum_q) * RAD_W'(isum_q);
        qsq     = RAD_W'(qsum_q) * RAD_W'(qsum_q);
        rad     = $unsigned(isq) + $unsigned(qsq);
        negk    = -{op_q.k[GAIN_W-1], op_q.k};
        prod    = PROD_W'(negk) * PROD_W'(qsum_q);
        num_s   = {prod, {FRAC_BITS{1'b0}}};
        num_neg = prod[PROD_W-1] ^ isum_q[SUM_W-1];
        num_mag = prod[PROD_W-1] ? $unsigned(-num_s) : $unsigned(num_s);
    end

    // arithmetic units
    logic              sq_done, dv_done;
    logic [ROOT_W-1:0] sq_root;
    logic [NUM_W-1:0]  dv_quo;

    cplf_isqrt #(.ROOT_W(ROOT_W)) u_sqrt (
        .clk  (clk),
        .rst  (rst),
        .go   (state_q == S_SQ_GO),
        .rad  (rad),
        .done (sq_done),
        .root (sq_root)
    );

    cplf_divu #(.N_W(NUM_W), .D_W(ROOT_W)) u_div (
        .clk  (clk),
        .rst  (rst),
        .go   (state_q == S_DV_GO),
        .num  (num_mag),
        .den  (sq_root),
        .done (dv_done),
        .quo  (dv_quo)
    );

    // result shaping
    logic signed [QS_W-1:0]   q_s;
    logic signed [FREQ_W-1:0] incr_clip;
    logic signed [GAIN_W:0]   d_plus1;
    logic signed [STEP_W-1:0] step;
    logic signed [FSUM_W-1:0] fsum;
    logic signed [FREQ_W-1:0] freq_sat;

    always_comb begin
        q_s = num_neg ? -$signed({1'b0, dv_quo}) : $signed({1'b0, dv_quo});
        if (q_s > INC_MAX)      incr_clip = INC_MAX[FREQ_W-1:0];
        else if (q_s < INC_MIN) incr_clip = INC_MIN[FREQ_W-1:0];
        else                    incr_clip = q_s[FREQ_W-1:0];

        d_plus1 = {op_q.d[GAIN_W-1], op_q.d} + 1'sb1;
        step    = STEP_W'(d_plus1) * STEP_W'(incr_q)
                - STEP_W'(op_q.d) * STEP_W'(prev_q);
        fsum    = FSUM_W'(freq_q) + FSUM_W'(step >>> FRAC_BITS);
        if (fsum > F_MAX)      freq_sat = F_MAX[FREQ_W-1:0];
        else if (fsum < F_MIN) freq_sat = F_MIN[FREQ_W-1:0];
        else                   freq_sat = fsum[FREQ_W-1:0];
    end

    // sequencing
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            gains_q <= reset_gains();
            op_q    <= reset_gains();
            isum_q  <= '0;
            qsum_q  <= '0;
            incr_q  <= '0;
            prev_q  <= '0;
            freq_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (cfg_we) begin
                gains_q.k <= cfg_k;
                gains_q.d <= cfg_d;
            end
            case (state_q)
                S_IDLE: begin
                    if (start) begin
                        isum_q  <= SUM_W'(i_prompt) + SUM_W'(i_early);
                        qsum_q  <= SUM_W'(q_prompt) + SUM_W'(q_early);
                        op_q    <= gains_q;
                        state_q <= S_SQ_GO;
                    end
                end
                S_SQ_GO:   state_q <= S_SQ_WAIT;
                S_SQ_WAIT: begin
                    if (sq_done) begin
                        if (sq_root == '0) begin
                            incr_q  <= '0;
                            state_q <= S_UPD;
                        end else begin
                            state_q <= S_DV_GO;
                        end
                    end
                end
                S_DV_GO:   state_q <= S_DV_WAIT;
                S_DV_WAIT: begin
                    if (dv_done) begin
                        incr_q  <= incr_clip;
                        state_q <= S_UPD;
                    end
                end
                S_UPD: begin
                    freq_q  <= freq_sat;
                    prev_q  <= incr_q;
                    done_q  <= 1'b1;
                    state_q <= S_IDLE;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign busy      = (state_q != S_IDLE);
    assign done      = done_q;
    assign freq_word = freq_q;
    assign incr_word = prev_q;

endmodule

// File: rtl/carrier_loop_filter_chk.sv
module carrier_loop_filter_chk #(
    parameter int FREQ_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [FREQ_W-1:0] freq_word,
    input logic [FREQ_W-1:0] incr_word
);
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_accept_busy_r9: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_busy_end_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    p_freq_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(freq_word));

    p_incr_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(incr_word));

endmodule

bind carrier_loop_filter carrier_loop_filter_chk #(.FREQ_W(FREQ_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .freq_word (freq_word),
    .incr_word (incr_word)
);

// File: tb/sim_carrier_loop_filter.sv
module sim_carrier_loop_filter;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic signed [15:0] i_prompt = '0, i_early = '0, q_prompt = '0, q_early = '0;
    logic cfg_we = 1'b0;
    logic signed [15:0] cfg_k = '0, cfg_d = '0;
    logic busy, done;
    logic signed [31:0] freq_word, incr_word;

    int n_checks = 0;
    int n_fail   = 0;
    bit reported = 1'b0;

    longint m_freq, m_prev, m_k, m_d;

    always #(CLK_PERIOD/2) clk = ~clk;

    carrier_loop_filter u0 (
        .clk(clk), .rst(rst), .start(start),
        .i_prompt(i_prompt), .i_early(i_early),
        .q_prompt(q_prompt), .q_early(q_early),
        .cfg_we(cfg_we), .cfg_k(cfg_k), .cfg_d(cfg_d),
        .busy(busy), .done(done),
        .freq_word(freq_word), .incr_word(incr_word)
    );

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        report();
    end

    task automatic check(string req, string what, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic longint isqrt_ref(longint v);
        longint r = 0;
        for (int b = 20; b >= 0; b--) begin
            longint t = r | (longint'(1) << b);
            if (t * t <= v) r = t;
        end
        return r;
    endfunction

    task automatic model_step(longint ip, longint ie, longint qp, longint qe);
        longint is = ip + ie;
        longint qs = qp + qe;
        longint mag = isqrt_ref(is * is + qs * qs);
        longint inc, num, st, f;
        if (mag == 0) inc = 0;
        else begin
            num = -m_k * qs * 16384;
            if (is < 0) num = -num;
            inc = num / mag;
        end
        if (inc > 64'sd2147483647)  inc = 64'sd2147483647;
        if (inc < -64'sd2147483648) inc = -64'sd2147483648;
        st = (m_d + 1) * inc - m_d * m_prev;
        f  = m_freq + (st >>> 14);
        if (f > 64'sd2147483647)  f = 64'sd2147483647;
        if (f < -64'sd2147483648) f = -64'sd2147483648;
        m_prev = inc;
        m_freq = f;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_freq = 0; m_prev = 0; m_k = -9; m_d = 21;
    endtask

    task automatic wait_done(string req);
        int t = 0;
        while (!done && t < 400) begin
            @(negedge clk);
            t++;
        end
        check(req, "done seen", longint'(done), 1);
    endtask

    task automatic run_update(string req, int ip, int ie, int qp, int qe);
        @(negedge clk);
        i_prompt = 16'(ip); i_early = 16'(ie);
        q_prompt = 16'(qp); q_early = 16'(qe);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(req);
        model_step(ip, ie, qp, qe);
        check(req, "freq_word", longint'(freq_word), m_freq);
        check(req, "incr_word", longint'(incr_word), m_prev);
    endtask

    task automatic write_gains(int k, int d);
        @(negedge clk);
        cfg_k = 16'(k); cfg_d = 16'(d); cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        m_k = k; m_d = d;
    endtask

    // R1: reset values, then an update that relies on the default gains
    task automatic t_reset();
        do_reset();
        check("R1", "freq after reset", longint'(freq_word), 0);
        check("R1", "incr after reset", longint'(incr_word), 0);
        check("R1", "busy after reset", longint'(busy), 0);
        check("R1", "done after reset", longint'(done), 0);
        run_update("R1", 100, 100, 50, 50);
    endtask

    // R2 R3 R5: mixed-sign sums, several patterns
    task automatic t_basic();
        run_update("R2", 300, -50, -700, 200);
        run_update("R3", 32767, 32767, -32768, -32768);
        run_update("R5", 7, -3, 1, 0);
    endtask

    // R3: sign of the in-phase sum, zero counts as positive
    task automatic t_sign();
        run_update("R3", -120, -80, 90, 10);
        run_update("R3", 0, 0, 500, -100);
        run_update("R3", 5, -5, -400, -1);
    endtask

    // R4: both sums zero
    task automatic t_zero();
        run_update("R4", 40, -40, 25, -25);
        check("R4", "zero increment", longint'(incr_word), 0);
        run_update("R4", 0, 0, 0, 0);
    endtask

    // R6: previous increment carried into the next step
    task automatic t_prev();
        run_update("R6", 1000, 0, 300, 0);
        run_update("R6", 1000, 0, 300, 0);
        run_update("R6", 1000, 0, -300, 0);
    endtask

    // R8: gain registers written and used
    task automatic t_gains();
        write_gains(-300, 0);
        run_update("R8", 200, 50, -90, 30);
        write_gains(1234, -7);
        run_update("R8", -600, 10, 70, 70);
    endtask

    // R7: drive the frequency word into both limits
    task automatic t_sat();
        do_reset();
        write_gains(-32768, 32767);
        run_update("R7", 0, 0, 500, 500);
        write_gains(-32768, 0);
        run_update("R7", 0, 0, -500, -500);
        write_gains(-32768, 32767);
        run_update("R7", 0, 0, 500, 500);
        check("R7", "positive limit", longint'(freq_word), 64'sd2147483647);
        do_reset();
        write_gains(-32768, 32767);
        run_update("R7", 0, 0, -500, -500);
        write_gains(-32768, 0);
        run_update("R7", 0, 0, 500, 500);
        write_gains(-32768, 32767);
        run_update("R7", 0, 0, -500, -500);
        check("R7", "negative limit", longint'(freq_word), -64'sd2147483648);
    endtask

    // R9: start during a run is ignored; done is one cycle
    task automatic t_busy();
        int extra = 0;
        do_reset();
        @(negedge clk);
        i_prompt = 16'sd400; i_early = 16'sd100; q_prompt = 16'sd60; q_early = -16'sd20;
        start = 1'b1;
        @(negedge clk);
        check("R9", "busy after accept", longint'(busy), 1);
        i_prompt = -16'sd900; i_early = 16'sd3; q_prompt = 16'sd800; q_early = 16'sd800;
        @(negedge clk);
        start = 1'b0;
        wait_done("R9");
        model_step(400, 100, 60, -20);
        check("R9", "freq from first request", longint'(freq_word), m_freq);
        check("R9", "incr from first request", longint'(incr_word), m_prev);
        @(negedge clk);
        check("R9", "done single cycle", longint'(done), 0);
        for (int c = 0; c < 150; c++) begin
            if (done) extra++;
            @(negedge clk);
        end
        check("R9", "no second result", extra, 0);
        check("R9", "idle after run", longint'(busy), 0);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_sign();
        t_zero();
        t_prev();
        t_gains();
        t_sat();
        t_busy();
        report();
    end

endmodule